// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns eight external interrupt request pins and one non-maskable interrupt pin into clean request signals for a downstream priority controller. Every pin is brought into the clock domain through a two-flop synchronizer. Each of the eight request pins can be set to one of two sensing modes. In low-level mode the request follows the pin. In falling-edge mode a high-to-low transition sets a latched flag, and the flag holds until the controller accepts the interrupt or software withdraws it. The non-maskable pin is edge sensed, and a control bit picks the active edge. A detected edge gives a single-cycle request pulse.

Software reaches the block through a small register bus with two addresses. Address 0 holds the control word: the per-pin sense bits and the non-maskable edge polarity. Address 1 holds the status word, which shows the live request of every pin. A latched edge flag can be withdrawn by writing 0 to its status bit, but only after software has read that bit as 1. An acceptance pulse from the controller also drops a latched flag.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, irq_req_o and nmi_req_o are 0 and the control word reads 0. Control value 0 means every pin is in low-level mode and the non-maskable pin is sensed on its falling edge.
- R2: In low-level mode (sense bit k = 0), irq_req_o[k] is high while pin k is low. It rises and falls two clock edges after the pin changes.
- R3: In falling-edge mode (sense bit k = 1), a high-to-low transition on pin k sets irq_req_o[k] on the third clock edge after the pin falls. The flag stays set after the pin returns high.
- R4: A high ack_i[k] at a clock edge clears a latched edge flag, and the request is low after that edge.
- R5: A write to address 1 with bit k = 0 clears latched flag k only when flag k has been read as 1 at address 1 since it was last set. Otherwise the write has no effect, and writing 1 never has an effect.
- R6: When a new falling edge sets flag k on the same edge as a clear (acknowledge or write), the flag stays set.
- R7: A read strobe loads reg_rdata_o on the next edge. Address 1 returns irq_req_o in bits 7:0 in either mode. Address 0 returns the sense bits in bits 7:0 (1 = falling edge, 0 = low level) and the non-maskable polarity in bit 8 (1 = rising, 0 = falling).
- R8: A transition of the non-maskable pin in the selected direction gives a one-cycle nmi_req_o pulse on the third edge after the pin changes. A transition in the other direction gives no pulse.
- R9: Switching pin k from edge mode to level mode discards its latched flag, so the flag stays clear when the pin is switched back to edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 8 | External request pins (asynchronous) |
| nmi_pin_i | input | 1 | Non-maskable request pin (asynchronous) |
| ack_i | input | 8 | Per-pin acceptance pulse from the controller |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 9 | Write data |
| reg_rdata_o | output | 9 | Registered read data |
| irq_req_o | output | 8 | Per-pin request / status flags |
| nmi_req_o | output | 1 | Non-maskable request pulse |

## Verification
Each result appears a fixed number of edges after its cause. A level request follows the pin two edges later. An edge flag and the non-maskable pulse appear three edges later. Register writes, read data and acknowledges take effect one edge later. The bench drives and samples only on falling clock edges and waits exactly that number of falling edges before it compares. For the coincidence case in R6, it places the acknowledge on the same rising edge that latches the new falling edge.

// File: rtl/eid_pkg.sv
`timescale 1ns/1ps
package eid_pkg;
  localparam int unsigned NUM_IRQ_DEF = 8;
  localparam int unsigned SYNC_DEF    = 2;
  localparam logic        ADDR_CTRL   = 1'b0;
  localparam logic        ADDR_STAT   = 1'b1;
endpackage

// File: rtl/eid_sync.sv
`timescale 1ns/1ps
module eid_sync #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= {WIDTH{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eid_irq_chan.sv
`timescale 1ns/1ps
module eid_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_mode_i,
  input  logic pin_s_i,
  input  logic ack_i,
  input  logic clr_wr_i,
  input  logic stat_rd_i,
  output logic req_o,
  output logic armed_o
);
  logic prev_q, flag_q, armed_q;
  logic fall, clr;

  assign fall = prev_q & ~pin_s_i;
  assign clr  = ack_i | (clr_wr_i & armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (!edge_mode_i) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (fall) begin
        // new edge wins over any clear
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (clr) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (stat_rd_i && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign req_o   = edge_mode_i ? flag_q : ~pin_s_i;
  assign armed_o = armed_q;
endmodule

// File: rtl/eid_nmi_edge.sv
`timescale 1ns/1ps
module eid_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_sel_i,
  input  logic pin_s_i,
  output logic req_o
);
  logic prev_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      req_q  <= rise_sel_i ? (~prev_q & pin_s_i) : (prev_q & ~pin_s_i);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/eid_regs.sv
`timescale 1ns/1ps
module eid_regs
  import eid_pkg::*;
#(
  parameter int unsigned NUM_IRQ = NUM_IRQ_DEF,
  localparam int unsigned DW     = NUM_IRQ + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NUM_IRQ-1:0] status_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NUM_IRQ-1:0] sense_o,
  output logic               nmi_rise_o,
  output logic [NUM_IRQ-1:0] clr_wr_o,
  output logic               stat_rd_o
);
  logic [NUM_IRQ-1:0] sense_q;
  logic               nmi_rise_q;
  logic [DW-1:0]      rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q    <= '0;
      nmi_rise_q <= 1'b0;
    end else if (wr_i && addr_i == ADDR_CTRL) begin
      sense_q    <= wdata_i[NUM_IRQ-1:0];
      nmi_rise_q <= wdata_i[NUM_IRQ];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_i) rdata_q <= (addr_i == ADDR_CTRL) ? {nmi_rise_q, sense_q}
                                                    : {1'b0, status_i};
  end

  assign clr_wr_o   = (wr_i && addr_i == ADDR_STAT) ? ~wdata_i[NUM_IRQ-1:0] : '0;
  assign stat_rd_o  = rd_i && addr_i == ADDR_STAT;
  assign sense_o    = sense_q;
  assign nmi_rise_o = nmi_rise_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/ext_irq_detect.sv
`timescale 1ns/1ps
module ext_irq_detect
  import eid_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = NUM_IRQ_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  localparam int unsigned DW         = NUM_IRQ + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_pin_i,
  input  logic               nmi_pin_i,
  input  logic [NUM_IRQ-1:0] ack_i,
  input  logic               reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic [NUM_IRQ-1:0] irq_req_o,
  output logic               nmi_req_o
);
  logic [NUM_IRQ-1:0] irq_sync, sense_q, clr_wr, armed;
  logic               nmi_sync, nmi_rise, stat_rd;

  eid_sync #(.WIDTH(NUM_IRQ + 1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({nmi_pin_i, irq_pin_i}),
    .q_o   ({nmi_sync, irq_sync})
  );

  eid_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .wdata_i   (reg_wdata_i),
    .status_i  (irq_req_o),
    .rdata_o   (reg_rdata_o),
    .sense_o   (sense_q),
    .nmi_rise_o(nmi_rise),
    .clr_wr_o  (clr_wr),
    .stat_rd_o (stat_rd)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chan
    eid_irq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .edge_mode_i(sense_q[k]),
      .pin_s_i    (irq_sync[k]),
      .ack_i      (ack_i[k]),
      .clr_wr_i   (clr_wr[k]),
      .stat_rd_i  (stat_rd),
      .req_o      (irq_req_o[k]),
      .armed_o    (armed[k])
    );
  end

  eid_nmi_edge u_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_sel_i(nmi_rise),
    .pin_s_i   (nmi_sync),
    .req_o     (nmi_req_o)
  );
endmodule

// File: rtl/eid_checker.sv
`timescale 1ns/1ps
module eid_checker
  import eid_pkg::*;
#(
  parameter int unsigned NUM_IRQ = NUM_IRQ_DEF,
  localparam int unsigned DW     = NUM_IRQ + 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_pin_i,
  input logic [NUM_IRQ-1:0] ack_i,
  input logic               reg_addr_i,
  input logic               reg_wr_i,
  input logic [DW-1:0]      reg_wdata_i,
  input logic [NUM_IRQ-1:0] irq_req_o,
  input logic               nmi_req_o,
  input logic [NUM_IRQ-1:0] sense_q,
  input logic [NUM_IRQ-1:0] armed,
  input logic               nmi_sync
);
  logic wr_stat;
  assign wr_stat = reg_wr_i && reg_addr_i == ADDR_STAT;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chk
    a_r2_level_follows_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sense_q[k] |-> (irq_req_o[k] == !$past(irq_pin_i[k], 2)));

    a_r3_edge_flag_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_q[k] && irq_req_o[k] && !ack_i[k] && !(wr_stat && !reg_wdata_i[k]))
        |=> (irq_req_o[k] || !sense_q[k]));

    a_r5_unread_clear_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_q[k] && irq_req_o[k] && !armed[k] && !ack_i[k])
        |=> (irq_req_o[k] || !sense_q[k]));
  end

  a_r8_nmi_needs_transition: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> ($past(nmi_sync) != $past(nmi_sync, 2)));
endmodule

bind ext_irq_detect eid_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_pin_i  (irq_pin_i),
  .ack_i      (ack_i),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_req_o  (irq_req_o),
  .nmi_req_o  (nmi_req_o),
  .sense_q    (sense_q),
  .armed      (armed),
  .nmi_sync   (nmi_sync)
);

// File: tb/tb_ext_irq_detect.sv
`timescale 1ns/1ps
module tb_ext_irq_detect;
  localparam int NI = 8;
  localparam int DW = NI + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] irq_pin_i = '1;
  logic          nmi_pin_i = 1'b1;
  logic [NI-1:0] ack_i = '0;
  logic          reg_addr_i = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic          reg_rd_i = 1'b0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic [NI-1:0] irq_req_o;
  logic          nmi_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  ext_irq_detect dut (.*);

  localparam logic [7:0] LVL_PIN [6] = '{8'hFF, 8'h00, 8'hA5, 8'h3C, 8'hFE, 8'h7F};
  localparam logic [7:0] LVL_EXP [6] = '{8'h00, 8'hFF, 8'h5A, 8'hC3, 8'h01, 8'h80};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic reg_write(input logic a, input logic [DW-1:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    wn(1);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic a);
    reg_addr_i = a; reg_rd_i = 1'b1;
    wn(1);
    reg_rd_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wn(3);
    rst_ni = 1'b1;
    wn(1);
    // R1 reset state
    chk("R1 irq_req", 16'(irq_req_o), 16'h0);
    chk("R1 nmi_req", 16'(nmi_req_o), 16'h0);
    reg_read(1'b0);
    chk("R1 ctrl", 16'(reg_rdata_o), 16'h0);

    // R2 level mode vectors
    for (int i = 0; i < 6; i++) begin
      irq_pin_i = LVL_PIN[i];
      wn(1);
      wn(1);
      chk("R2 level", 16'(irq_req_o), 16'(LVL_EXP[i]));
    end
    // R7 status read in level mode
    irq_pin_i = ~8'h5A;
    wn(2);
    reg_read(1'b1);
    chk("R7 level status", 16'(reg_rdata_o), 16'h05A);

    irq_pin_i = '1;
    wn(3);
    reg_write(1'b0, 9'h0FF);
    reg_read(1'b0);
    chk("R7 ctrl readback", 16'(reg_rdata_o), 16'h0FF);
    chk("R3 no flag after mode switch", 16'(irq_req_o), 16'h0);

    // R3 edge latch
    irq_pin_i = 8'hFE;
    wn(2);
    chk("R3 not yet", 16'(irq_req_o), 16'h0);
    wn(1);
    chk("R3 set", 16'(irq_req_o), 16'h01);
    irq_pin_i = '1;
    wn(3);
    chk("R3 held", 16'(irq_req_o), 16'h01);

    // R5 write 0 without prior read
    reg_write(1'b1, 9'h000);
    chk("R5 unread clear ignored", 16'(irq_req_o), 16'h01);
    reg_write(1'b1, 9'h1FF);
    chk("R5 write one ignored", 16'(irq_req_o), 16'h01);
    reg_read(1'b1);
    chk("R7 edge status", 16'(reg_rdata_o), 16'h001);
    reg_write(1'b1, 9'h1FE);
    chk("R5 read-then-clear", 16'(irq_req_o), 16'h0);

    // R4 acknowledge
    irq_pin_i = 8'hFD;
    wn(3);
    chk("R3 pin1 set", 16'(irq_req_o), 16'h02);
    irq_pin_i = '1;
    ack_i = 8'h02;
    wn(1);
    ack_i = '0;
    chk("R4 ack clears", 16'(irq_req_o), 16'h0);

    // R6 edge beats coincident acknowledge
    irq_pin_i = 8'hFB;
    wn(3);
    irq_pin_i = '1;
    wn(3);
    chk("R6 pre", 16'(irq_req_o), 16'h04);
    irq_pin_i = 8'hFB;
    wn(2);
    ack_i = 8'h04;
    wn(1);
    ack_i = '0;
    chk("R6 edge wins", 16'(irq_req_o), 16'h04);
    irq_pin_i = '1;
    ack_i = 8'h04;
    wn(1);
    ack_i = '0;
    chk("R4 later ack", 16'(irq_req_o), 16'h0);

    // R9 mode switch discards flag
    irq_pin_i = 8'hF7;
    wn(3);
    irq_pin_i = '1;
    wn(3);
    chk("R9 pre", 16'(irq_req_o), 16'h08);
    reg_write(1'b0, 9'h0F7);
    chk("R9 level view", 16'(irq_req_o), 16'h0);
    reg_write(1'b0, 9'h0FF);
    chk("R9 flag gone", 16'(irq_req_o), 16'h0);

    // R8 non-maskable, falling selected
    nmi_pin_i = 1'b0;
    wn(2);
    chk("R8 not yet", 16'(nmi_req_o), 16'h0);
    wn(1);
    chk("R8 fall pulse", 16'(nmi_req_o), 16'h1);
    wn(1);
    chk("R8 one cycle", 16'(nmi_req_o), 16'h0);
    nmi_pin_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wn(1);
      chk("R8 rise ignored", 16'(nmi_req_o), 16'h0);
    end
    reg_write(1'b0, 9'h1FF);
    nmi_pin_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      wn(1);
      chk("R8 fall ignored", 16'(nmi_req_o), 16'h0);
    end
    nmi_pin_i = 1'b1;
    wn(3);
    chk("R8 rise pulse", 16'(nmi_req_o), 16'h1);
    wn(1);
    chk("R8 rise one cycle", 16'(nmi_req_o), 16'h0);

    finish_run();
  end
endmodule